// File: doc/BRIEF.md
# Dual-Clock Bit-Serial Elastic FIFO

This block buffers a serial bit stream between two clock domains. Each lane is a one-bit-wide queue. It has a write clock and a read clock, and the two may be unrelated or may be the same clock. A producer presents a bit with a write enable, and the bit is taken while the lane reports input-ready. The read side works as first-word fall-through: when output-ready is high, the oldest bit is already on the data output, and a read enable advances the queue to the next bit. The data output floats to high impedance while its output enable is low.

Two status outputs summarise the fill level. The half-full flag compares the stored count with half the depth. The near-limit flag rises when the lane is close to empty or close to full, within a fixed margin of eight bits at either end. The bit parked on the output is not part of the stored count, so a lane holds DEPTH bits in storage plus the one on display. The top module places `LANES` identical, independent lanes side by side. The default is two lanes, and all lanes share one asynchronous active-low reset.

Pointers cross between the clock domains as Gray codes through two flip-flop stages. A read therefore reaches the write-side flags through two write-clock registers. A write reaches output-ready through two synchroniser registers and the output register, which makes three read-clock stages. The occupancy flags are derived on the write side and may report a level that is a little too high for a few write clocks after a read.

Top module: `serial_elastic_fifo`

## Requirements
- R1: A bit is stored on a rising write-clock edge only when that lane's write enable and input-ready are both high. Write-side activity with write enable low changes no flag and adds no bit.
- R2: Bits leave a lane in the order they were accepted. While output-ready is high, the oldest bit is on the data output, and a rising read-clock edge with read enable high moves on to the next bit.
- R3: The bit on the data output is not counted as stored. With no reads, a lane accepts exactly DEPTH+1 bits before input-ready stays low.
- R4: Once the lane has settled, half-full is high exactly when the stored count is at least DEPTH/2 (32 for the default depth of 64).
- R5: Once the lane has settled, near-limit is high exactly when the stored count is at most 8 or at least DEPTH-8.
- R6: Input-ready is low when DEPTH bits are stored. It returns high within a few write clocks after a read frees a storage location.
- R7: Output-ready rises after a bit is accepted into an empty lane and falls once the last bit is read. While read enable is low, output-ready and the data output hold their values.
- R8: A lane's data output is high impedance while its output enable is low, and it shows the head bit while its output enable is high.
- R9: While reset is low, input-ready and output-ready are low, half-full is low and near-limit is high. After reset is released, input-ready goes high.
- R10: Lanes are independent. Traffic on one lane changes no flag or data on another, and a lane whose write and read clocks are the same clock behaves as specified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for all lanes |
| wr_clk | input | LANES | Write clock, one per lane |
| wr_en | input | LANES | Write enable, one per lane |
| wr_bit | input | LANES | Serial data in, one per lane |
| in_rdy | output | LANES | Input-ready, write-clock domain |
| rd_clk | input | LANES | Read clock, one per lane |
| rd_en | input | LANES | Read enable (advance to the next bit) |
| rd_oe | input | LANES | Output enable; low floats the data output |
| rd_bit | output | LANES | Serial data out, high impedance when not enabled |
| out_rdy | output | LANES | Output-ready, read-clock domain |
| half_full | output | LANES | Stored count at least DEPTH/2 |
| near_limit | output | LANES | Stored count at most 8, or free locations at most 8 |

## Verification
The bench builds the block with its defaults: DEPTH of 64, a margin of 8 and two lanes. Lane 0 runs on unrelated write and read clocks. Lane 1 runs both sides on one clock. The small depth lets a one-bit-at-a-time walk from empty past full check every flag threshold (9, 10, 32, 33, 56, 57 and DEPTH+1 accepted bits), followed by a full drain, all within a short run. Random traffic on both lanes at once, with different write and read rates, keeps lane 0 near empty and near full while the other lane is busy, which tests both lane independence and the asynchronous pointer crossing.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    localparam int unsigned SFIFO_GW = 16;

    function automatic logic [SFIFO_GW-1:0] bin2gray(input logic [SFIFO_GW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [SFIFO_GW-1:0] gray2bin(input logic [SFIFO_GW-1:0] g);
        logic [SFIFO_GW-1:0] b;
        b[SFIFO_GW-1] = g[SFIFO_GW-1];
        for (int i = SFIFO_GW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/sfifo_gray_sync.sv
module sfifo_gray_sync #(
    parameter int unsigned W      = 7,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe_d [STAGES];
    logic [W-1:0] pipe_q [STAGES];

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                pipe_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                pipe_q[i] <= pipe_d[i];
            end
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/sfifo_lane.sv
module sfifo_lane
    import sfifo_pkg::*;
#(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned MARGIN = 8
) (
    input  logic rst_n,
    input  logic wclk,
    input  logic wen,
    input  logic wdat,
    output logic in_rdy,
    input  logic rclk,
    input  logic ren,
    output logic out_rdy,
    output logic obit,
    output logic half_full,
    output logic near_limit
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned PW = AW + 1;
    localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);
    localparam logic [PW-1:0] LOW_CNT  = PW'(MARGIN);
    localparam logic [PW-1:0] HIGH_CNT = PW'(DEPTH - MARGIN);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic          live;
    } wr_st_t;

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic          hold;
        logic          bitv;
    } rd_st_t;

    logic          mem [DEPTH];
    wr_st_t        wr_d, wr_q;
    rd_st_t        rd_d, rd_q;
    logic [PW-1:0] rgray_w;
    logic [PW-1:0] wgray_r;
    logic [PW-1:0] rptr_w;
    logic [PW-1:0] count_w;
    logic          wr_take;
    logic          mem_empty;
    logic          pop;
    logic          load;

    // Read pointer into the write domain, write pointer into the read domain.
    sfifo_gray_sync #(.W(PW), .STAGES(2)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .d(rd_q.gray), .q(rgray_w)
    );
    sfifo_gray_sync #(.W(PW), .STAGES(2)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .d(wr_q.gray), .q(wgray_r)
    );

    // ---------------- write domain ----------------
    always_comb begin
        rptr_w     = PW'(gray2bin(SFIFO_GW'(rgray_w)));
        count_w    = wr_q.ptr - rptr_w;
        in_rdy     = wr_q.live && (count_w != FULL_CNT);
        half_full  = (count_w >= HALF_CNT);
        near_limit = (count_w <= LOW_CNT) || (count_w >= HIGH_CNT);
        wr_take    = wen && in_rdy;

        wr_d      = wr_q;
        wr_d.live = 1'b1;
        if (wr_take) begin
            wr_d.ptr = wr_q.ptr + 1'b1;
        end
        wr_d.gray = PW'(bin2gray(SFIFO_GW'(wr_d.ptr)));
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= '0;
        end else begin
            wr_q <= wr_d;
        end
    end

    always_ff @(posedge wclk) begin
        if (wr_take) begin
            mem[wr_q.ptr[AW-1:0]] <= wdat;
        end
    end

    // ---------------- read domain ----------------
    always_comb begin
        mem_empty = (rd_q.gray == wgray_r);
        pop       = ren && rd_q.hold;
        load      = (!rd_q.hold || pop) && !mem_empty;

        rd_d = rd_q;
        if (load) begin
            rd_d.bitv = mem[rd_q.ptr[AW-1:0]];
            rd_d.ptr  = rd_q.ptr + 1'b1;
            rd_d.hold = 1'b1;
        end else if (pop) begin
            rd_d.hold = 1'b0;
        end
        rd_d.gray = PW'(bin2gray(SFIFO_GW'(rd_d.ptr)));
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign out_rdy = rd_q.hold;
    assign obit    = rd_q.bitv;
endmodule

// File: rtl/serial_elastic_fifo.sv
module serial_elastic_fifo #(
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned MARGIN = 8,
    parameter int unsigned LANES  = 2
) (
    input  logic             rst_n,
    input  logic [LANES-1:0] wr_clk,
    input  logic [LANES-1:0] wr_en,
    input  logic [LANES-1:0] wr_bit,
    output logic [LANES-1:0] in_rdy,
    input  logic [LANES-1:0] rd_clk,
    input  logic [LANES-1:0] rd_en,
    input  logic [LANES-1:0] rd_oe,
    output wire  [LANES-1:0] rd_bit,
    output logic [LANES-1:0] out_rdy,
    output logic [LANES-1:0] half_full,
    output logic [LANES-1:0] near_limit
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic head_bit;

        sfifo_lane #(.DEPTH(DEPTH), .MARGIN(MARGIN)) u_lane (
            .rst_n      (rst_n),
            .wclk       (wr_clk[g]),
            .wen        (wr_en[g]),
            .wdat       (wr_bit[g]),
            .in_rdy     (in_rdy[g]),
            .rclk       (rd_clk[g]),
            .ren        (rd_en[g]),
            .out_rdy    (out_rdy[g]),
            .obit       (head_bit),
            .half_full  (half_full[g]),
            .near_limit (near_limit[g])
        );

        assign rd_bit[g] = rd_oe[g] ? head_bit : 1'bz;
    end
endmodule

// File: rtl/sfifo_lane_chk.sv
module sfifo_lane_chk #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned PW    = 7
) (
    input logic          rst_n,
    input logic          wclk,
    input logic          rclk,
    input logic          wen,
    input logic          ren,
    input logic          in_rdy,
    input logic          out_rdy,
    input logic          obit,
    input logic          half_full,
    input logic          near_limit,
    input logic          mem_empty,
    input logic [PW-1:0] count_w
);
    // R3
    no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        count_w <= PW'(DEPTH));

    // R1
    no_stray_write_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !wen |=> count_w <= $past(count_w));

    // R6
    full_flags_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (!in_rdy && count_w != 0) |-> (half_full && near_limit));

    // R7
    out_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (out_rdy && !ren) |=> (out_rdy && $stable(obit)));

    // R2
    drain_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (ren && out_rdy && mem_empty) |=> !out_rdy);

    // R9
    reset_state_chk: assert property (@(posedge wclk)
        !rst_n |-> (!in_rdy && !half_full && near_limit));
endmodule

bind sfifo_lane sfifo_lane_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
    .rst_n      (rst_n),
    .wclk       (wclk),
    .rclk       (rclk),
    .wen        (wen),
    .ren        (ren),
    .in_rdy     (in_rdy),
    .out_rdy    (out_rdy),
    .obit       (obit),
    .half_full  (half_full),
    .near_limit (near_limit),
    .mem_empty  (mem_empty),
    .count_w    (count_w)
);

// File: tb/tb_serial_elastic_fifo.sv
module tb_serial_elastic_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int RCLK_PERIOD = 14;
    localparam int DEPTH = 64;
    localparam int MARGIN = 8;

    logic       rst_n;
    logic       wclk0, rclk0, clk1;
    logic [1:0] wen_r, wdat_r, ren_r, oe_r;
    logic [1:0] in_rdy, out_rdy, half_full, near_limit;
    wire  [1:0] rd_bit;

    int checks = 0;
    int fails = 0;
    bit qa[$];
    bit qb[$];

    serial_elastic_fifo #(.DEPTH(DEPTH), .MARGIN(MARGIN), .LANES(2)) dut (
        .rst_n(rst_n), .wr_clk({clk1, wclk0}), .wr_en(wen_r), .wr_bit(wdat_r),
        .in_rdy(in_rdy), .rd_clk({clk1, rclk0}), .rd_en(ren_r), .rd_oe(oe_r),
        .rd_bit(rd_bit), .out_rdy(out_rdy), .half_full(half_full),
        .near_limit(near_limit)
    );

    initial wclk0 = 0;
    always #(CLK_PERIOD/2) wclk0 = ~wclk0;
    initial rclk0 = 0;
    always #(RCLK_PERIOD/2) rclk0 = ~rclk0;
    initial clk1 = 0;
    always #(CLK_PERIOD/2) clk1 = ~clk1;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic int qsize(input int ch);
        return (ch == 0) ? qa.size() : qb.size();
    endfunction

    task automatic wr_cycle(input int ch, input bit en, input bit b);
        if (ch == 0) @(negedge wclk0); else @(negedge clk1);
        wen_r[ch]  = en;
        wdat_r[ch] = b;
        if (en && in_rdy[ch]) begin
            if (ch == 0) qa.push_back(b); else qb.push_back(b);
        end
    endtask

    task automatic rd_cycle(input int ch, input bit en);
        bit exp;
        if (ch == 0) @(negedge rclk0); else @(negedge clk1);
        ren_r[ch] = en;
        if (en && out_rdy[ch]) begin
            if (qsize(ch) == 0) begin
                chk(0, $sformatf("R2 lane%0d read with empty model", ch), 1, 0);
            end else begin
                exp = (ch == 0) ? qa.pop_front() : qb.pop_front();
                chk(rd_bit[ch] == exp, $sformatf("R2 lane%0d data order", ch),
                    int'(rd_bit[ch]), int'(exp));
            end
        end
    endtask

    task automatic settle(input int ch);
        wr_cycle(ch, 0, 0);
        rd_cycle(ch, 0);
        repeat (12) @(posedge rclk0);
        @(negedge wclk0);
    endtask

    task automatic check_flags(input int ch, input string tag);
        int n  = qsize(ch);
        int st = (n > 0) ? n - 1 : 0;
        chk(out_rdy[ch] == (n > 0), $sformatf("R7 lane%0d out_rdy %s", ch, tag),
            int'(out_rdy[ch]), int'(n > 0));
        chk(in_rdy[ch] == (st != DEPTH), $sformatf("R6 lane%0d in_rdy %s", ch, tag),
            int'(in_rdy[ch]), int'(st != DEPTH));
        chk(half_full[ch] == (st >= DEPTH/2), $sformatf("R4 lane%0d half_full st=%0d %s", ch, st, tag),
            int'(half_full[ch]), int'(st >= DEPTH/2));
        chk(near_limit[ch] == (st <= MARGIN || st >= DEPTH - MARGIN),
            $sformatf("R5 lane%0d near_limit st=%0d %s", ch, st, tag),
            int'(near_limit[ch]), int'(st <= MARGIN || st >= DEPTH - MARGIN));
    endtask

    task automatic rand_run(input int ch, input int n, input int wpct, input int rpct);
        fork
            begin
                for (int i = 0; i < n; i++) begin
                    wr_cycle(ch, ($urandom % 100) < wpct, 1'($urandom));
                end
                wr_cycle(ch, 0, 0);
            end
            begin
                for (int i = 0; i < n; i++) begin
                    rd_cycle(ch, ($urandom % 100) < rpct);
                end
                rd_cycle(ch, 0);
            end
        join
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired (all requirements) actual=1 expected=0");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit held;
        void'($urandom(32'h5EED1));
        rst_n = 0; wen_r = 0; wdat_r = 0; ren_r = 0; oe_r = 2'b11;
        repeat (3) @(negedge wclk0);
        for (int ch = 0; ch < 2; ch++) begin
            chk(in_rdy[ch] == 0, "R9 in_rdy in reset", int'(in_rdy[ch]), 0);
            chk(out_rdy[ch] == 0, "R9 out_rdy in reset", int'(out_rdy[ch]), 0);
            chk(half_full[ch] == 0, "R9 half_full in reset", int'(half_full[ch]), 0);
            chk(near_limit[ch] == 1, "R9 near_limit in reset", int'(near_limit[ch]), 1);
        end
        rst_n = 1;
        settle(0);
        chk(in_rdy == 2'b11, "R9 in_rdy after reset", int'(in_rdy), 3);

        // Walk lane 0 from empty past full, one bit at a time (R3 R4 R5 R6).
        for (int k = 1; k <= DEPTH + 2; k++) begin
            wr_cycle(0, 1, (k == 1) ? 1'b1 : 1'($urandom));
            // R1: write enable low with toggling data must add nothing
            wr_cycle(0, 0, 1'b1);
            wr_cycle(0, 0, 1'b0);
            settle(0);
            check_flags(0, $sformatf("walk k=%0d", k));
        end
        chk(qa.size() == DEPTH + 1, "R3 accepted bits before full", qa.size(), DEPTH + 1);
        chk(in_rdy[0] == 0, "R1 write refused while not ready", int'(in_rdy[0]), 0);

        // R7: head holds while read enable is low.
        held = rd_bit[0];
        repeat (5) rd_cycle(0, 0);
        chk(out_rdy[0] == 1 && rd_bit[0] == held, "R7 head held", int'(rd_bit[0]), int'(held));

        // R8: output enable.
        @(negedge wclk0); oe_r[0] = 0;
        @(negedge wclk0);
        chk(rd_bit[0] !== 1'b1, "R8 output floats with oe low", int'(rd_bit[0] === 1'b1), 0);
        oe_r[0] = 1;
        @(negedge wclk0);
        chk(rd_bit[0] === 1'b1, "R8 head bit with oe high", int'(rd_bit[0]), 1);

        // Drain lane 0 (R2 R6 R7).
        for (int i = 0; i < DEPTH + 20; i++) rd_cycle(0, 1);
        settle(0);
        chk(qa.size() == 0, "R2 lane0 drained", qa.size(), 0);
        check_flags(0, "after drain");

        // Random traffic: lane 0 asynchronous, lane 1 on one clock, concurrently (R10).
        fork
            rand_run(0, 3000, 60, 45);
            rand_run(1, 3000, 50, 50);
        join
        settle(0); settle(1);
        check_flags(0, "random fill-biased");
        check_flags(1, "random same clock");

        rand_run(1, 400, 90, 10);
        settle(1);
        check_flags(1, "lane1 fill");
        check_flags(0, "R10 lane0 untouched by lane1");

        fork
            rand_run(0, 3000, 40, 70);
            rand_run(1, 3000, 70, 40);
        join
        settle(0); settle(1);
        check_flags(0, "random drain-biased");
        check_flags(1, "R10 lane1 after concurrent run");

        for (int i = 0; i < DEPTH + 20; i++) rd_cycle(1, 1);
        settle(1);
        chk(qb.size() == 0, "R10 lane1 drained", qb.size(), 0);
        check_flags(1, "lane1 empty");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule